// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus and flags two fault conditions. The first is a clock-low timeout: a down-counter is held at a programmable reload value for as long as the clock line is high. It counts one step per system clock only while the clock line is low. When it runs out, it emits a one-cycle pulse that software uses to reset the serial interface by disabling and re-enabling it. The reload value is given in system clocks, so it can be sized for 25 ms at the chosen clock rate or shortened for simulation.

The second condition is a bus-free timeout. When both lines have been high for more than `FREE_TICKS` periods of the serial clock source, the bus is treated as idle. Those periods arrive as single-cycle `src_tick` strobes. A free timeout gets the same response as a STOP condition: the STOP flag and the interrupt are both set. The block also recognises a real STOP condition, which is the data line rising while the clock line is high. Both flags are sticky until software clears them. Each feature has its own enable.

Top module: `bus_timeout_mon`

## Requirements
- R1: While `scl` is high or `low_to_en` is 0, the low-timeout counter is loaded with `low_reload`. A single high cycle of `scl` therefore restarts the full low-time window.
- R2: With `low_to_en`=1 and reload value R, `low_to_pulse` rises for one cycle after the (R+1)th consecutive rising clock edge at which `scl` is sampled low. It then repeats after every further R+1 low edges.
- R3: With `low_to_en`=0, `low_to_pulse` stays 0 however long `scl` is low.
- R4: With `free_to_en`=1, `free_to_pulse` rises for one cycle after the (`FREE_TICKS`+1)th `src_tick` seen while `scl` and `sda` are both high. Cycles without a tick do not advance the count. The pulse never occurs when `free_to_en`=0.
- R5: Only one free timeout is reported per idle interval. Detection re-arms only after `scl` or `sda` is sampled low.
- R6: A free timeout sets `stop_flag` and `irq` on the same edge as it raises `free_to_pulse`.
- R7: A STOP condition sets `stop_flag` and `irq`. A STOP condition is `sda` sampled low and then high on consecutive edges, with `scl` high at both.
- R8: `stop_flag` stays set until `stop_clr` is sampled high, and `irq` stays set until `irq_clr` is sampled high. Each clear acts only on its own flag. A set event on the same edge as a clear wins.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Clock line level (synchronous to clk) |
| sda | input | 1 | Data line level (synchronous to clk) |
| src_tick | input | 1 | One-cycle strobe per serial clock source period |
| low_to_en | input | 1 | Enable clock-low timeout detection |
| free_to_en | input | 1 | Enable bus-free timeout detection |
| low_reload | input | LOW_W | Low-timeout length in system clocks, minus one |
| stop_clr | input | 1 | Clear STOP flag |
| irq_clr | input | 1 | Clear interrupt |
| low_to_pulse | output | 1 | One-cycle clock-low timeout pulse |
| free_to_pulse | output | 1 | One-cycle bus-free timeout pulse |
| stop_flag | output | 1 | Sticky STOP-detected flag |
| irq | output | 1 | Sticky interrupt |

## Verification
The bench builds the block with `LOW_W`=6, which makes short reload values practical. Every reload value from 0 to 12 is swept against every low stretch from 0 to 30 cycles. The pulse count and the position of the first pulse are checked against floor(L/(R+1)) and R+1. `FREE_TICKS` keeps its default of 10. The tick count is swept from 0 to 14 at tick spacings of 1 to 3 cycles, which covers both sides of the free-timeout threshold. Directed cases cover re-arming, disables, the STOP condition and clear priority.

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
  parameter int LOW_W      = 22,
  parameter int FREE_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             src_tick,
  input  logic             low_to_en,
  input  logic             free_to_en,
  input  logic [LOW_W-1:0] low_reload,
  input  logic             stop_clr,
  input  logic             irq_clr,
  output logic             low_to_pulse,
  output logic             free_to_pulse,
  output logic             stop_flag,
  output logic             irq
);
  localparam int FREE_W = $clog2(FREE_TICKS + 1);
  localparam logic [FREE_W-1:0] FREE_LAST = FREE_W'(FREE_TICKS);

  logic [LOW_W-1:0]  low_cnt;
  logic [FREE_W-1:0] free_cnt;
  logic              free_done, scl_q, sda_q;

  wire low_run   = low_to_en & ~scl;
  wire low_hit   = low_run & (low_cnt == '0);
  wire idle      = scl & sda;
  wire free_step = free_to_en & idle & src_tick & ~free_done;
  wire free_hit  = free_step & (free_cnt == FREE_LAST);
  wire stop_seen = scl & scl_q & sda & ~sda_q;
  wire set_evt   = free_hit | stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt       <= '0;
      low_to_pulse  <= 1'b0;
      free_cnt      <= '0;
      free_done     <= 1'b0;
      free_to_pulse <= 1'b0;
      stop_flag     <= 1'b0;
      irq           <= 1'b0;
      scl_q         <= 1'b1;
      sda_q         <= 1'b1;
    end else begin
      low_cnt      <= (!low_run || low_hit) ? low_reload : low_cnt - 1'b1;
      low_to_pulse <= low_hit;

      if (!free_to_en || !idle) begin
        free_cnt  <= '0;
        free_done <= 1'b0;
      end else if (free_step) begin
        if (free_hit) free_done <= 1'b1;
        else          free_cnt  <= free_cnt + 1'b1;
      end
      free_to_pulse <= free_hit;

      stop_flag <= set_evt | (stop_flag & ~stop_clr);
      irq       <= set_evt | (irq & ~irq_clr);
      scl_q     <= scl;
      sda_q     <= sda;
    end
  end
endmodule

module bus_timeout_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda,
  input logic src_tick,
  input logic low_to_en,
  input logic stop_clr,
  input logic irq_clr,
  input logic low_to_pulse,
  input logic free_to_pulse,
  input logic stop_flag,
  input logic irq
);
  a_r1_no_pulse_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl |=> !low_to_pulse);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !low_to_en |=> !low_to_pulse);
  a_r4_free_needs_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    free_to_pulse |-> $past(src_tick && scl && sda));
  a_r5_single_free_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    free_to_pulse |=> !free_to_pulse);
  a_r6_free_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    free_to_pulse |-> (stop_flag && irq));
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !stop_clr) |=> stop_flag);
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind bus_timeout_mon bus_timeout_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .src_tick(src_tick),
  .low_to_en(low_to_en), .stop_clr(stop_clr), .irq_clr(irq_clr),
  .low_to_pulse(low_to_pulse), .free_to_pulse(free_to_pulse),
  .stop_flag(stop_flag), .irq(irq)
);

// File: tb/tb_bus_timeout_mon.sv
`timescale 1ns/1ps
module tb_bus_timeout_mon;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1, src_tick = 0;
  logic low_to_en = 0, free_to_en = 0, stop_clr = 0, irq_clr = 0;
  logic [5:0] low_reload = '0;
  logic low_to_pulse, free_to_pulse, stop_flag, irq;
  int checks = 0, failures = 0, fp_n = 0;
  bit done = 0;

  bus_timeout_mon #(.LOW_W(6), .FREE_TICKS(10)) dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .src_tick(src_tick),
    .low_to_en(low_to_en), .free_to_en(free_to_en), .low_reload(low_reload),
    .stop_clr(stop_clr), .irq_clr(irq_clr), .low_to_pulse(low_to_pulse),
    .free_to_pulse(free_to_pulse), .stop_flag(stop_flag), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cyc_s;
    cyc;
    if (free_to_pulse) fp_n++;
  endtask

  task automatic low_trial(input int r, input int l, input bit en);
    int n = 0, first = 0;
    low_reload = 6'(r);
    low_to_en = en;
    cyc;
    scl = 0;
    for (int i = 1; i <= l; i++) begin
      cyc;
      if (low_to_pulse) begin
        n++;
        if (first == 0) first = i;
      end
    end
    scl = 1;
    cyc;
    if (low_to_pulse) n++;
    chk(en ? "R2 pulse count" : "R3 pulse count", n, en ? l / (r + 1) : 0);
    if (en) chk("R2 first pulse", first, (l >= r + 1) ? r + 1 : 0);
  endtask

  task automatic rearm;
    scl = 0;
    cyc_s;
    scl = 1;
    cyc_s;
  endtask

  task automatic ticks(input int t, input int s);
    for (int k = 0; k < t; k++) begin
      src_tick = 1;
      cyc_s;
      src_tick = 0;
      for (int j = 1; j < s; j++) cyc_s;
    end
    repeat (3) cyc_s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc;
    rst_n = 1;
    cyc;
    chk("R9 low_to_pulse", low_to_pulse, 0);
    chk("R9 free_to_pulse", free_to_pulse, 0);
    chk("R9 stop_flag", stop_flag, 0);
    chk("R9 irq", irq, 0);

    for (int r = 0; r <= 12; r++)
      for (int l = 0; l <= 30; l++)
        low_trial(r, l, 1'b1);

    low_trial(2, 40, 1'b0);
    low_trial(0, 10, 1'b0);

    // R1: a single high cycle restarts the low window
    begin
      int n = 0;
      low_reload = 6'd5;
      low_to_en = 1;
      cyc;
      for (int rep = 0; rep < 4; rep++) begin
        scl = 0;
        repeat (5) begin cyc; if (low_to_pulse) n++; end
        scl = 1;
        cyc;
        if (low_to_pulse) n++;
      end
      chk("R1 high restarts window", n, 0);
      scl = 0;
      repeat (6) begin cyc; if (low_to_pulse) n++; end
      scl = 1;
      cyc;
      chk("R1 full window after restart", n, 1);
      low_to_en = 0;
    end

    for (int s = 1; s <= 3; s++)
      for (int t = 0; t <= 14; t++) begin
        free_to_en = 1;
        stop_clr = 1;
        irq_clr = 1;
        fp_n = 0;
        rearm;
        stop_clr = 0;
        irq_clr = 0;
        fp_n = 0;
        ticks(t, s);
        chk("R4 free pulse count", fp_n, (t >= 11) ? 1 : 0);
        chk("R6 stop_flag", stop_flag, (t >= 11) ? 1 : 0);
        chk("R6 irq", irq, (t >= 11) ? 1 : 0);
      end

    // R4: no ticks means no advance
    stop_clr = 1; irq_clr = 1; rearm; stop_clr = 0; irq_clr = 0;
    fp_n = 0;
    repeat (60) cyc_s;
    chk("R4 no ticks no pulse", fp_n, 0);

    // R4: disabled
    free_to_en = 0;
    fp_n = 0;
    ticks(20, 1);
    chk("R4 disabled no pulse", fp_n, 0);
    chk("R4 disabled no stop_flag", stop_flag, 0);

    // R5: once per interval, re-armed by a low line
    free_to_en = 1;
    rearm;
    fp_n = 0;
    ticks(30, 1);
    chk("R5 single pulse per interval", fp_n, 1);
    rearm;
    ticks(11, 2);
    chk("R5 rearm via scl", fp_n, 2);
    sda = 0;
    cyc_s;
    sda = 1;
    cyc_s;
    ticks(11, 1);
    chk("R5 rearm via sda", fp_n, 3);
    free_to_en = 0;

    // R7 / R8: real STOP, sticky flags, separate clears
    stop_clr = 1; irq_clr = 1; cyc; stop_clr = 0; irq_clr = 0; cyc;
    chk("R8 clear stop_flag", stop_flag, 0);
    chk("R8 clear irq", irq, 0);
    sda = 0; cyc; cyc;
    chk("R7 no stop before rise", stop_flag, 0);
    sda = 1; cyc;
    chk("R7 stop_flag on STOP", stop_flag, 1);
    chk("R7 irq on STOP", irq, 1);
    repeat (10) cyc;
    chk("R8 stop_flag held", stop_flag, 1);
    chk("R8 irq held", irq, 1);
    stop_clr = 1; cyc; stop_clr = 0; cyc;
    chk("R8 stop_clr clears flag", stop_flag, 0);
    chk("R8 stop_clr leaves irq", irq, 1);
    irq_clr = 1; cyc; irq_clr = 0; cyc;
    chk("R8 irq_clr clears irq", irq, 0);

    // R7: data rising while clock low is not a STOP
    scl = 0; cyc; sda = 0; cyc; sda = 1; cyc; scl = 1; cyc; cyc;
    chk("R7 rise with scl low ignored", stop_flag, 0);

    // R8: set wins over clear
    sda = 0; cyc; cyc;
    sda = 1; stop_clr = 1; irq_clr = 1; cyc;
    stop_clr = 0; irq_clr = 0;
    chk("R8 set beats stop_clr", stop_flag, 1);
    chk("R8 set beats irq_clr", irq, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule